// File: doc/BRIEF.md
# Banked Scratchpad Memory with Per-Bank Arbitration

This block is an on-chip scratchpad shared by several load/store requesters. The word address space is spread over a power-of-two number of banks. Each bank has its own single-ported RAM and its own round-robin arbiter. Because consecutive words fall in different banks, requesters that touch different banks are all served in the same clock cycle. Requesters that collide on one bank are served one per cycle, and the others are held off by a low `ready`.

Each requester port has a valid/ready request channel and a response channel. A request is accepted in the cycle where `req_valid` and `req_ready` are both high. A stalled requester keeps its request stable until it is accepted. An accepted read returns its data on the same port exactly one cycle later, marked by `rsp_valid`. An accepted write updates the RAM and produces no response.

Each bank runs a small state machine with three states. `BK_IDLE` means the bank served nothing in the previous cycle. `BK_RD` means it served a read and is presenting the data with the requester tag. `BK_WR` means it served a write. Every cycle the bank moves to `BK_RD` on a read grant, to `BK_WR` on a write grant, or to `BK_IDLE` when it has no grant, whatever its current state. The same state register drives the response outputs.

Top module: `bm_banked_memory`

## Requirements
- R1: The bank index is address bits [2:0] (log2 of the bank count). The row inside the bank is the address shifted right by 3. Every one of the 256 word addresses therefore maps to its own storage location.
- R2: Requests that target pairwise different banks are all accepted in the same cycle, up to one per bank. A bank with at least one pending request always grants one of them.
- R3: Each bank accepts at most one request per cycle. A requester with a request in a busy bank that is not granted sees `req_ready` low.
- R4: Each bank grants round-robin. Priority starts at the requester one index above the last winner of that bank, and wraps around. After reset the priority starts at requester 0.
- R5: A requester that holds its request stable is accepted within at most 4 cycles, which is the number of requesters. It is therefore stalled for at most 3 consecutive cycles.
- R6: An accepted read raises `rsp_valid` on the same port exactly one cycle later. `rsp_valid` is never high in any other cycle.
- R7: An accepted write stores its data. A later read of that address returns the most recently written value, and the write produces no response.
- R8: During and right after reset, `rsp_valid` is low. `req_ready` is never high for a port whose `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS | Request present, one bit per requester |
| req_write | input | NUM_PORTS | 1 = store, 0 = load, per requester |
| req_addr | input | NUM_PORTS x ADDR_W | Word address per requester |
| req_wdata | input | NUM_PORTS x DATA_W | Store data per requester |
| req_ready | output | NUM_PORTS | Request accepted this cycle |
| rsp_valid | output | NUM_PORTS | Load data present on this port |
| rsp_rdata | output | NUM_PORTS x DATA_W | Load data per requester |

## Verification
Some properties are checked by assertions on every cycle. Each bank grants at most one requester, and only one that asked. A bank with pending requests never stays idle. No port is stalled beyond the round-robin bound. A response appears only one cycle after an accepted load on the same port, and `ready` never rises without `valid`. Other behaviours need the bench's scenarios to show them, because the bench keeps its own reference memory and its own model of the round-robin pointers. Those behaviours are correct address-to-row mapping, read-after-write data, the exact grant order among colliding requesters, and full parallel acceptance when all ports hit distinct banks.

// File: rtl/bm_pkg.sv
package bm_pkg;

    // Operation a bank performed in the previous cycle.
    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_RD   = 2'd1,
        BK_WR   = 2'd2
    } bank_state_e;

    // Index width that stays at least one bit for degenerate counts.
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/bm_rr_arbiter.sv
module bm_rr_arbiter
    import bm_pkg::*;
#(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = idx_width(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] grant,
    output logic [IDX_W-1:0]   grant_idx,
    output logic               any_grant
);

    logic [IDX_W-1:0] prio_q;

    // Search starts at the priority pointer and wraps around.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any_grant = 1'b0;
        for (int off = 0; off < NUM_REQ; off++) begin
            int cand;
            cand = (int'(prio_q) + off) % NUM_REQ;
            if (!any_grant && req[cand]) begin
                grant[cand] = 1'b1;
                grant_idx   = IDX_W'(cand);
                any_grant   = 1'b1;
            end
        end
    end

    // Pointer moves to the requester just past the last winner.
    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
        end else if (any_grant) begin
            if (int'(grant_idx) == NUM_REQ - 1) begin
                prio_q <= '0;
            end else begin
                prio_q <= grant_idx + IDX_W'(1);
            end
        end
    end

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    assert_work_conserving_R2: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|grant));

endmodule

// File: rtl/bm_bank.sv
module bm_bank
    import bm_pkg::*;
#(
    parameter int ROW_W  = 5,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 2,
    localparam int ROWS  = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TAG_W-1:0]  tag_in,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data
);

    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] rd_q;
    logic [TAG_W-1:0]  tag_q;
    bank_state_e       state_q;
    bank_state_e       state_d;

    // Storage: one access per cycle, read data registered.
    always_ff @(posedge clk) begin
        if (sel && wr) begin
            mem[row] <= wdata;
        end
        if (sel && !wr) begin
            rd_q  <= mem[row];
            tag_q <= tag_in;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = BK_IDLE;
        if (sel) begin
            state_d = wr ? BK_WR : BK_RD;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_tag   = tag_q;
        rsp_data  = rd_q;
        unique case (state_q)
            BK_IDLE: rsp_valid = 1'b0;
            BK_RD:   rsp_valid = 1'b1;
            BK_WR:   rsp_valid = 1'b0;
            default: rsp_valid = 1'b0;
        endcase
    end

    assert_bank_rd_follows_load_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(sel && !wr));

endmodule

// File: rtl/bm_banked_memory.sv
module bm_banked_memory
    import bm_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_PORTS-1:0]             req_valid,
    input  logic [NUM_PORTS-1:0]             req_write,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] req_addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] req_wdata,
    output logic [NUM_PORTS-1:0]             req_ready,
    output logic [NUM_PORTS-1:0]             rsp_valid,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] rsp_rdata
);

    localparam int BANK_W = idx_width(NUM_BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int PORT_W = idx_width(NUM_PORTS);
    localparam int CNT_W  = PORT_W + 1;

    logic [NUM_BANKS-1:0][NUM_PORTS-1:0] gnt_bp;
    logic [NUM_BANKS-1:0]                bk_rsp_v;
    logic [NUM_BANKS-1:0][PORT_W-1:0]    bk_tag;
    logic [NUM_BANKS-1:0][DATA_W-1:0]    bk_data;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [NUM_PORTS-1:0] hit;
        logic [PORT_W-1:0]    win;
        logic                 sel;

        // Bank decode from the low address bits.
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
            assign hit[p] = req_valid[p] && (req_addr[p][BANK_W-1:0] == BANK_W'(b));
        end

        bm_rr_arbiter #(.NUM_REQ(NUM_PORTS)) i_arb (
            .clk       (clk),
            .rst       (rst),
            .req       (hit),
            .grant     (gnt_bp[b]),
            .grant_idx (win),
            .any_grant (sel)
        );

        bm_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W), .TAG_W(PORT_W)) i_bank (
            .clk       (clk),
            .rst       (rst),
            .sel       (sel),
            .wr        (req_write[win]),
            .row       (req_addr[win][ADDR_W-1:BANK_W]),
            .wdata     (req_wdata[win]),
            .tag_in    (win),
            .rsp_valid (bk_rsp_v[b]),
            .rsp_tag   (bk_tag[b]),
            .rsp_data  (bk_data[b])
        );
    end

    // Stall feedback: a port is ready when its bank granted it.
    always_comb begin
        req_ready = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                req_ready[p] = req_ready[p] | gnt_bp[b][p];
            end
        end
    end

    // Response routing by requester tag.
    always_comb begin
        rsp_valid = '0;
        rsp_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bk_rsp_v[b] && bk_tag[b] == PORT_W'(p)) begin
                    rsp_valid[p] = 1'b1;
                    rsp_rdata[p] = bk_data[b];
                end
            end
        end
    end

    // Per-port stall counters, used only to bound waiting time.
    logic [NUM_PORTS-1:0][CNT_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (req_valid[p] && !req_ready[p]) begin
                    wait_cnt[p] <= wait_cnt[p] + CNT_W'(1);
                end else begin
                    wait_cnt[p] <= '0;
                end
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        assert_ready_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
            req_ready[p] |-> req_valid[p]);

        assert_rsp_after_load_R6: assert property (@(posedge clk) disable iff (rst)
            rsp_valid[p] |-> $past(req_valid[p] && req_ready[p] && !req_write[p]));

        assert_stall_bound_R5: assert property (@(posedge clk) disable iff (rst)
            (req_valid[p] && !req_ready[p]) |-> (wait_cnt[p] < CNT_W'(NUM_PORTS - 1)));
    end

endmodule

// File: tb/test_bm_banked_memory.sv
module test_bm_banked_memory;

    localparam int NP = 4;
    localparam int NB = 8;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst;
    always #10 clk = ~clk;

    logic [NP-1:0]         req_valid, req_write, req_ready, rsp_valid;
    logic [NP-1:0][AW-1:0] req_addr;
    logic [NP-1:0][DW-1:0] req_wdata, rsp_rdata;

    bm_banked_memory #(.NUM_PORTS(NP), .NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) i_bm_banked_memory (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    int            rr_ptr  [NB];
    bit            exp_v   [NP];
    logic [DW-1:0] exp_d   [NP];
    int            stall_len [NP];
    bit            cur_v [NP];
    bit            cur_w [NP];
    logic [AW-1:0] cur_a [NP];
    logic [DW-1:0] cur_d [NP];
    bit            last_g [NP];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int addr, input int salt);
        return DW'(32'h5A00_0000 ^ (addr * 32'h0101_0101) ^ (salt * 32'h0003_0007));
    endfunction

    // One clock cycle: check last responses, drive requests, check stalls.
    task automatic cycle();
        bit g [NP];
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            check("R6 rsp_valid", rsp_valid[p], exp_v[p]);
            if (exp_v[p]) check("R1 R7 read data", rsp_rdata[p], exp_d[p]);
        end
        for (int p = 0; p < NP; p++) begin
            req_valid[p] = cur_v[p];
            req_write[p] = cur_w[p];
            req_addr[p]  = cur_a[p];
            req_wdata[p] = cur_d[p];
        end
        #1;
        for (int p = 0; p < NP; p++) g[p] = 1'b0;
        for (int b = 0; b < NB; b++) begin
            bit found;
            found = 1'b0;
            for (int off = 0; off < NP; off++) begin
                int q;
                q = (rr_ptr[b] + off) % NP;
                if (!found && cur_v[q] && (int'(cur_a[q]) % NB) == b) begin
                    g[q] = 1'b1;
                    found = 1'b1;
                    rr_ptr[b] = (q + 1) % NP;
                end
            end
        end
        for (int p = 0; p < NP; p++) begin
            check("R2 R3 R4 R8 ready", req_ready[p], g[p]);
            exp_v[p] = 1'b0;
            if (g[p]) begin
                if (cur_w[p]) ref_mem[cur_a[p]] = cur_d[p];
                else begin
                    exp_v[p] = 1'b1;
                    exp_d[p] = ref_mem[cur_a[p]];
                end
                stall_len[p] = 0;
            end else if (cur_v[p]) begin
                stall_len[p]++;
                check("R5 stall bound", (stall_len[p] <= NP - 1), 1);
            end else begin
                stall_len[p] = 0;
            end
            last_g[p] = g[p];
        end
    endtask

    task automatic drain();
        for (int k = 0; k < NP + 2; k++) begin
            for (int p = 0; p < NP; p++) if (last_g[p] || !cur_v[p]) cur_v[p] = 1'b0;
            cycle();
        end
    endtask

    initial begin
        int p0;
        int grant_at [NP];
        void'($urandom(32'd20240611));
        rst = 1'b1;
        req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
        for (int b = 0; b < NB; b++) rr_ptr[b] = 0;
        for (int p = 0; p < NP; p++) begin
            exp_v[p] = 0; stall_len[p] = 0; cur_v[p] = 0; cur_w[p] = 0;
            cur_a[p] = '0; cur_d[p] = '0; last_g[p] = 0;
        end
        repeat (3) @(negedge clk);
        check("R8 reset rsp_valid", rsp_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 after reset rsp_valid", rsp_valid, 0);
        check("R8 after reset ready", req_ready, 0);

        // Fill: every port writes a distinct bank each cycle (R2, R7).
        for (int k = 0; k < DEPTH / NP; k++) begin
            for (int p = 0; p < NP; p++) begin
                cur_v[p] = 1; cur_w[p] = 1;
                cur_a[p] = AW'(k * NP + p);
                cur_d[p] = pattern(k * NP + p, 0);
            end
            cycle();
            for (int p = 0; p < NP; p++) check("R2 parallel accept", last_g[p], 1);
        end
        drain();

        // R1: overwrite one row of bank 1 and read neighbours sharing the bank.
        cur_v[0] = 1; cur_w[0] = 1; cur_a[0] = 8'h09; cur_d[0] = 32'hDEAD_BEEF;
        cycle(); drain();
        cur_v[0] = 1; cur_w[0] = 0; cur_a[0] = 8'h01;
        cur_v[1] = 1; cur_w[1] = 0; cur_a[1] = 8'h09;
        cur_v[2] = 1; cur_w[2] = 0; cur_a[2] = 8'h11;
        cur_v[3] = 1; cur_w[3] = 0; cur_a[3] = 8'h0A;
        cycle(); drain();

        // R4: all ports load from bank 3, grant order follows the pointer.
        p0 = rr_ptr[3];
        for (int p = 0; p < NP; p++) begin
            cur_v[p] = 1; cur_w[p] = 0; cur_a[p] = AW'(3 + NB * p); grant_at[p] = -1;
        end
        for (int k = 0; k < NP; k++) begin
            cycle();
            for (int p = 0; p < NP; p++) if (last_g[p]) begin
                grant_at[p] = k; cur_v[p] = 0;
            end
        end
        for (int p = 0; p < NP; p++) check("R4 grant order", grant_at[p], (p - p0 + NP) % NP);
        drain();

        // Constrained random traffic with bank collisions.
        for (int k = 0; k < 3000; k++) begin
            for (int p = 0; p < NP; p++) begin
                if (!(cur_v[p] && !last_g[p])) begin
                    cur_v[p] = ($urandom % 4) != 0;
                    cur_w[p] = ($urandom % 5) < 2;
                    if ($urandom % 2 == 0) cur_a[p] = AW'((($urandom % 32) << 3) | ($urandom % 2));
                    else cur_a[p] = AW'($urandom % DEPTH);
                    cur_d[p] = $urandom;
                end
            end
            cycle();
        end
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule